// File: doc/BRIEF.md
# Dual Word FIFO with Programmable Level Flags

This block holds two synchronous 32-bit word queues side by side, one for the transmit path and one for the receive path. Each queue has a push port, a pop port with a registered read-data output, and its own programmable pair of thresholds. One is the "almost empty" level and the other is the "almost full" margin. The block reports a single status word. Each queue's level flags appear in inverted form in that word: not empty, not almost empty, not almost full and not full. The word also carries a transmit-activity bit and three sticky error bits for lost or invented words.

A surrounding register decoder writes the thresholds, issues the three flush/reset pulses and clears error bits. It also reads back the status word, each queue's fixed capacity and its current occupancy. A board-level reset pulse empties both queues, restores the default thresholds and wipes the error bits. Each queue also has its own flush pulse, which empties only that queue.

Top module: `dual_pflag_fifo`

## Requirements
- R1: Words leave each queue in the order they were pushed; the read data appears on the edge that accepts the pop and holds until the next accepted pop.
- R2: A push into a full queue (without a pop in the same cycle) is dropped; the occupancy stays at the capacity and the dropped word never appears at the read side.
- R3: A pop from an empty queue changes neither the occupancy nor the read data, which keeps the previously popped word.
- R4: Status bit 12 (receive) and bit 8 (transmit) read 1 exactly when the queue holds at least one word; bit 15 (receive) and bit 11 (transmit) read 1 exactly when it holds fewer words than its capacity.
- R5: With the almost-empty threshold AE taken from threshold-write bits 15:0, status bit 13 (receive) / bit 9 (transmit) reads 1 exactly when the occupancy is greater than AE.
- R6: With the almost-full margin AF taken from threshold-write bits 23:16, status bit 14 (receive) / bit 10 (transmit) reads 1 exactly when the occupancy plus AF is below the capacity.
- R7: After reset and after a board-reset pulse (flush bit 0), both queues' thresholds read back as AE = 32 and AF = 32, i.e. 0x00200020 with AE in bits 15:0 and AF in bits 23:16.
- R8: Sticky error bits are transmit overrun at status bit 21, receive underrun at bit 22 and receive overrun at bit 23. Each is set by its event and held until a 1 is written to the matching clear bit (clear bits 0, 1, 2 map to status bits 21, 22, 23). A set in the same cycle as a clear wins.
- R9: Flush bit 1 empties only the transmit queue and flush bit 2 empties only the receive queue. Flush bit 0 empties both queues and clears all sticky error bits.
- R10: The capacity outputs read the queue depth (64 by default) and the level outputs read the current occupancy, both as 20-bit values.
- R11: Status bit 7 follows the transmit-line-busy input; all status bits not named in R4 to R8 read 0.
- R12: A push and a pop in the same cycle on a full queue both take effect: the oldest word is read out, the new word is stored, and the occupancy stays at the capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_req | input | 3 | Pulses: bit 0 board reset, bit 1 transmit flush, bit 2 receive flush |
| thr_we | input | 2 | Threshold write enables: bit 0 transmit, bit 1 receive |
| thr_wdata | input | 24 | Threshold write data: 15:0 almost-empty level, 23:16 almost-full margin |
| tx_thr | output | 32 | Transmit threshold readback |
| rx_thr | output | 32 | Receive threshold readback |
| tx_push | input | 1 | Transmit queue push |
| tx_wdata | input | 32 | Transmit push data |
| tx_pop | input | 1 | Transmit queue pop |
| tx_rdata | output | 32 | Transmit read data (registered) |
| rx_push | input | 1 | Receive queue push |
| rx_wdata | input | 32 | Receive push data |
| rx_pop | input | 1 | Receive queue pop |
| rx_rdata | output | 32 | Receive read data (registered) |
| tx_line_busy | input | 1 | Transmit activity indication, reflected in status bit 7 |
| err_clr | input | 3 | Write-one-to-clear for status bits 21, 22, 23 |
| status | output | 32 | Status word |
| tx_cap | output | 20 | Transmit queue capacity |
| rx_cap | output | 20 | Receive queue capacity |
| tx_level | output | 20 | Transmit queue occupancy |
| rx_level | output | 20 | Receive queue occupancy |

## Verification
All occupancy, flag, error and threshold state sits in registers, and the status word and level outputs are decoded combinationally from them. Every effect of a push, pop, flush, threshold write or error clear is therefore visible right after the one clock edge that accepts it. The popped word is also due after that same edge, since the read-data register loads on the pop itself. The bench changes inputs on the falling edge, lets exactly one rising edge pass, and compares every output at the next falling edge against counts and thresholds it tracks arithmetically. A sweep fills each queue to capacity and drains it again under several threshold pairs, which covers every occupancy against every flag boundary.

// File: rtl/pff_pkg.sv
package pff_pkg;
    // status word layout
    localparam int ST_BUSY   = 7;
    localparam int ST_TX_LO  = 8;
    localparam int ST_RX_LO  = 12;
    localparam int ST_ERR_LO = 21;
    // flush request bits
    localparam int FL_BOARD  = 0;
    localparam int FL_TX     = 1;
    localparam int FL_RX     = 2;
    // default thresholds
    localparam int THR_DEF   = 32;
    localparam int NCH       = 2;
    localparam int NERR      = 3;
endpackage

// File: rtl/pff_store.sv
module pff_store #(
    parameter int DW = 32,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [AW:0]   count
);
    localparam int DEPTH = 1 << AW;
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
        logic [DW-1:0] rd;
    } store_t;

    store_t s_d, s_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic is_full, is_empty, do_push, do_pop;

    always_comb begin
        is_full  = (s_q.cnt == FULL_CNT);
        is_empty = (s_q.cnt == '0);
        do_pop   = pop && !is_empty && !flush;
        do_push  = push && (!is_full || do_pop) && !flush;
        s_d      = s_q;
        if (flush) begin
            s_d.wp  = '0;
            s_d.rp  = '0;
            s_d.cnt = '0;
        end else begin
            if (do_push) s_d.wp = s_q.wp + 1'b1;
            if (do_pop) begin
                s_d.rp = s_q.rp + 1'b1;
                s_d.rd = mem_q[s_q.rp];
            end
            case ({do_push, do_pop})
                2'b10:   s_d.cnt = s_q.cnt + 1'b1;
                2'b01:   s_d.cnt = s_q.cnt - 1'b1;
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[s_q.wp] <= wdata;
    end

    assign rdata = s_q.rd;
    assign count = s_q.cnt;

    // R10: occupancy never exceeds the capacity
    p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= FULL_CNT);
    // R2: a push into a full queue with no pop is dropped
    p_drop_on_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && is_full && !pop && !flush) |=> (s_q.cnt == FULL_CNT) && $stable(s_q.wp));
    // R3: a pop on an empty queue leaves the read data alone
    p_underrun_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && is_empty && !flush) |=> $stable(s_q.rd));
    // R12: push plus pop on a full queue keeps it full
    p_full_swap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && is_full && !flush) |=> (s_q.cnt == FULL_CNT));
    // R9: a flush leaves the queue empty
    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (s_q.cnt == '0));
endmodule

// File: rtl/pff_flags.sv
module pff_flags #(
    parameter int AW = 6
) (
    input  logic [AW:0] count,
    input  logic [15:0] ae_thr,
    input  logic [7:0]  af_thr,
    output logic [3:0]  nib      // {not full, not almost full, not almost empty, not empty}
);
    localparam int DEPTH = 1 << AW;
    localparam int SW    = (AW + 1 > 16) ? AW + 2 : 17;
    localparam logic [SW-1:0] DEPTH_W = SW'(DEPTH);

    logic [SW-1:0] cnt_w;

    always_comb begin
        cnt_w  = SW'(count);
        nib[0] = (cnt_w != '0);
        nib[1] = (cnt_w > SW'(ae_thr));
        nib[2] = ((cnt_w + SW'(af_thr)) < DEPTH_W);
        nib[3] = (cnt_w < DEPTH_W);
    end
endmodule

// File: rtl/pff_sticky.sv
module pff_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wipe,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] err
);
    typedef struct packed {
        logic [N-1:0] bits;
    } sticky_t;

    sticky_t e_d, e_q;

    always_comb begin
        e_d = e_q;
        if (wipe) e_d.bits = '0;
        else      e_d.bits = (e_q.bits & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign err = e_q.bits;

    // R8: an event always lands, even against a clear
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wipe |=> ((err & $past(set)) == $past(set)));
    // R8: a bit that is not cleared stays set
    p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wipe |=> ((err & ($past(err) & ~$past(clr))) == ($past(err) & ~$past(clr))));
endmodule

// File: rtl/dual_pflag_fifo.sv
module dual_pflag_fifo
    import pff_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 6,
    parameter int CW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    flush_req,
    input  logic [1:0]    thr_we,
    input  logic [23:0]   thr_wdata,
    output logic [31:0]   tx_thr,
    output logic [31:0]   rx_thr,
    input  logic          tx_push,
    input  logic [DW-1:0] tx_wdata,
    input  logic          tx_pop,
    output logic [DW-1:0] tx_rdata,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_wdata,
    input  logic          rx_pop,
    output logic [DW-1:0] rx_rdata,
    input  logic          tx_line_busy,
    input  logic [2:0]    err_clr,
    output logic [31:0]   status,
    output logic [CW-1:0] tx_cap,
    output logic [CW-1:0] rx_cap,
    output logic [CW-1:0] tx_level,
    output logic [CW-1:0] rx_level
);
    localparam int DEPTH = 1 << AW;
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [NCH-1:0][15:0] ae;
        logic [NCH-1:0][7:0]  af;
    } thr_t;

    thr_t t_d, t_q;

    logic [NCH-1:0]  push_v, pop_v, flush_v;
    logic [DW-1:0]   wd_v  [NCH];
    logic [DW-1:0]   rd_v  [NCH];
    logic [AW:0]     cnt_v [NCH];
    logic [3:0]      nib_v [NCH];
    logic [NERR-1:0] err_set, err_q;

    // threshold registers
    always_comb begin
        t_d = t_q;
        if (flush_req[FL_BOARD]) begin
            for (int c = 0; c < NCH; c++) begin
                t_d.ae[c] = 16'(THR_DEF);
                t_d.af[c] = 8'(THR_DEF);
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (thr_we[c]) begin
                    t_d.ae[c] = thr_wdata[15:0];
                    t_d.af[c] = thr_wdata[23:16];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                t_q.ae[c] <= 16'(THR_DEF);
                t_q.af[c] <= 8'(THR_DEF);
            end
        end else begin
            t_q <= t_d;
        end
    end

    assign push_v  = {rx_push, tx_push};
    assign pop_v   = {rx_pop, tx_pop};
    assign wd_v[0] = tx_wdata;
    assign wd_v[1] = rx_wdata;
    assign flush_v = {flush_req[FL_RX], flush_req[FL_TX]} | {NCH{flush_req[FL_BOARD]}};

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
            pff_store #(.DW(DW), .AW(AW)) u_store (
                .clk   (clk),
                .rst_n (rst_n),
                .flush (flush_v[ch]),
                .push  (push_v[ch]),
                .pop   (pop_v[ch]),
                .wdata (wd_v[ch]),
                .rdata (rd_v[ch]),
                .count (cnt_v[ch])
            );
            pff_flags #(.AW(AW)) u_flags (
                .count  (cnt_v[ch]),
                .ae_thr (t_q.ae[ch]),
                .af_thr (t_q.af[ch]),
                .nib    (nib_v[ch])
            );
        end
    endgenerate

    // error events: tx overrun, rx underrun, rx overrun
    always_comb begin
        err_set[0] = tx_push && !tx_pop && (cnt_v[0] == FULL_CNT) && !flush_v[0];
        err_set[1] = rx_pop && (cnt_v[1] == '0) && !flush_v[1];
        err_set[2] = rx_push && !rx_pop && (cnt_v[1] == FULL_CNT) && !flush_v[1];
    end

    pff_sticky #(.N(NERR)) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .wipe  (flush_req[FL_BOARD]),
        .set   (err_set),
        .clr   (err_clr),
        .err   (err_q)
    );

    always_comb begin
        status = '0;
        status[ST_BUSY]                 = tx_line_busy;
        status[ST_TX_LO +: 4]           = nib_v[0];
        status[ST_RX_LO +: 4]           = nib_v[1];
        status[ST_ERR_LO +: NERR]       = err_q;
    end

    assign tx_thr   = {8'h00, t_q.af[0], t_q.ae[0]};
    assign rx_thr   = {8'h00, t_q.af[1], t_q.ae[1]};
    assign tx_rdata = rd_v[0];
    assign rx_rdata = rd_v[1];
    assign tx_cap   = CW'(DEPTH);
    assign rx_cap   = CW'(DEPTH);
    assign tx_level = CW'(cnt_v[0]);
    assign rx_level = CW'(cnt_v[1]);

    // R4: receive not-empty agrees with the occupancy output
    p_rx_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_RX_LO] == (rx_level != '0));
    // R5: an empty queue is also almost empty
    p_ae_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !status[ST_RX_LO] |-> !status[ST_RX_LO+1]);
    // R6: a full queue is also almost full
    p_af_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !status[ST_RX_LO+3] |-> !status[ST_RX_LO+2]);
    // R7: board reset restores default thresholds
    p_thr_default_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req[FL_BOARD] |=> (tx_thr == 32'h0020_0020) && (rx_thr == 32'h0020_0020));
    // R9: board reset wipes the error bits
    p_board_wipe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req[FL_BOARD] |=> (status[ST_ERR_LO +: NERR] == '0));
endmodule

// File: tb/dual_pflag_fifo_tb_top.sv
module dual_pflag_fifo_tb_top;
    localparam int D = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  flush_req = '0;
    logic [1:0]  thr_we = '0;
    logic [23:0] thr_wdata = '0;
    logic [31:0] tx_thr, rx_thr;
    logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [31:0] tx_wdata = '0, rx_wdata = '0, tx_rdata, rx_rdata;
    logic        tx_line_busy = 1'b0;
    logic [2:0]  err_clr = '0;
    logic [31:0] status;
    logic [19:0] tx_cap, rx_cap, tx_level, rx_level;

    always #2 clk = ~clk;

    dual_pflag_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .flush_req(flush_req), .thr_we(thr_we),
        .thr_wdata(thr_wdata), .tx_thr(tx_thr), .rx_thr(rx_thr),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .tx_line_busy(tx_line_busy), .err_clr(err_clr), .status(status),
        .tx_cap(tx_cap), .rx_cap(rx_cap), .tx_level(tx_level), .rx_level(rx_level)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // bench model
    int tcnt, rcnt, tae, taf, rae, raf;
    logic [2:0] err;

    task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic logic [3:0] nib(int c, int ae, int af);
        return {c < D, (c + af) < D, c > ae, c > 0};
    endfunction

    function automatic logic [31:0] exp_status();
        logic [31:0] s;
        s = '0;
        s[7]     = tx_line_busy;
        s[11:8]  = nib(tcnt, tae, taf);
        s[15:12] = nib(rcnt, rae, raf);
        s[23:21] = err;
        return s;
    endfunction

    task automatic check_all(string req);
        check(req, "status", status, exp_status());
        check(req, "rx_level", {12'h0, rx_level}, 32'(rcnt));
        check(req, "tx_level", {12'h0, tx_level}, 32'(tcnt));
    endtask

    task automatic push(bit rx, logic [31:0] d);
        if (rx) begin rx_push = 1; rx_wdata = d; end
        else    begin tx_push = 1; tx_wdata = d; end
        @(negedge clk);
        rx_push = 0; tx_push = 0;
        if (rx) begin if (rcnt < D) rcnt++; else err[2] = 1; end
        else    begin if (tcnt < D) tcnt++; else err[0] = 1; end
    endtask

    task automatic pop(bit rx);
        if (rx) rx_pop = 1; else tx_pop = 1;
        @(negedge clk);
        rx_pop = 0; tx_pop = 0;
        if (rx) begin if (rcnt > 0) rcnt--; else err[1] = 1; end
        else    begin if (tcnt > 0) tcnt--; end
    endtask

    task automatic set_thr(bit rx, int ae, int af);
        thr_we = rx ? 2'b10 : 2'b01;
        thr_wdata = {8'(af), 16'(ae)};
        @(negedge clk);
        thr_we = 0;
        if (rx) begin rae = ae; raf = af; end else begin tae = ae; taf = af; end
    endtask

    task automatic flush(logic [2:0] f);
        flush_req = f;
        @(negedge clk);
        flush_req = 0;
        if (f[0]) begin tcnt = 0; rcnt = 0; err = 0; tae = 32; taf = 32; rae = 32; raf = 32; end
        if (f[1]) tcnt = 0;
        if (f[2]) rcnt = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int aes [5] = '{32, 0, 5, 63, 64};
        int afs [5] = '{32, 0, 10, 255, 1};
        tcnt = 0; rcnt = 0; err = 0; tae = 32; taf = 32; rae = 32; raf = 32;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // reset state
        check("R7", "tx_thr", tx_thr, 32'h0020_0020);
        check("R7", "rx_thr", rx_thr, 32'h0020_0020);
        check("R10", "tx_cap", {12'h0, tx_cap}, 32'(D));
        check("R10", "rx_cap", {12'h0, rx_cap}, 32'(D));
        check("R4", "status", status, 32'h0000_CC00);

        set_thr(0, 7, 9);
        check("R5", "tx_thr", tx_thr, 32'h0009_0007);

        // sweep fill and drain of the receive queue under several thresholds
        for (int s = 0; s < 5; s++) begin
            set_thr(1, aes[s], afs[s]);
            check("R6", "rx_thr", rx_thr, {8'h0, 8'(afs[s]), 16'(aes[s])});
            for (int k = 0; k < D; k++) begin
                push(1, 32'hA000_0000 + 32'(s * 256 + k));
                check_all("R4 R5 R6 R10");
            end
            push(1, 32'hDEAD_0000);   // dropped
            check_all("R2 R8");
            for (int k = 0; k < D; k++) begin
                pop(1);
                check("R1", "rx_rdata", rx_rdata, 32'hA000_0000 + 32'(s * 256 + k));
                check_all("R4 R5 R6");
            end
            pop(1);                   // underrun
            check("R3", "rx_rdata", rx_rdata, 32'hA000_0000 + 32'(s * 256 + D - 1));
            check_all("R3 R8");
            err_clr = 3'b110;
            @(negedge clk);
            err_clr = 0;
            err[2:1] = 0;
            check_all("R8");
        end

        // transmit queue fill, overrun, drain, empty pop
        for (int k = 0; k < D; k++) begin
            push(0, 32'hB000_0000 + 32'(k));
            check_all("R4 R5 R6");
        end
        push(0, 32'hDEAD_BEEF);
        check_all("R2 R8");
        for (int k = 0; k < D; k++) begin
            pop(0);
            check("R1", "tx_rdata", tx_rdata, 32'hB000_0000 + 32'(k));
        end
        pop(0);
        check("R3", "tx_rdata", tx_rdata, 32'hB000_003F);
        check_all("R3 R8");
        err_clr = 3'b001;
        @(negedge clk);
        err_clr = 0;
        err[0] = 0;
        check_all("R8");

        // R12: push and pop together on a full queue
        for (int k = 0; k < D; k++) push(1, 32'hC000_0000 + 32'(k));
        rx_push = 1; rx_pop = 1; rx_wdata = 32'hC000_1000;
        @(negedge clk);
        rx_push = 0; rx_pop = 0;
        check("R12", "rx_rdata", rx_rdata, 32'hC000_0000);
        check_all("R12");

        // R8: set wins over a clear in the same cycle
        rx_push = 1; rx_wdata = 32'h1; err_clr = 3'b100;
        @(negedge clk);
        rx_push = 0; err_clr = 0;
        err[2] = 1;
        check_all("R8");

        // R11: transmit-busy bit
        tx_line_busy = 1;
        #1;
        check_all("R11");
        tx_line_busy = 0;

        // R9: flushes
        for (int k = 0; k < 5; k++) push(0, 32'hE000_0000 + 32'(k));
        flush(3'b100);
        check_all("R9");
        pop(0);
        check("R9", "tx_rdata", tx_rdata, 32'hE000_0000);
        push(1, 32'h5); push(1, 32'h6);
        flush(3'b010);
        check_all("R9");
        push(0, 32'h7);
        set_thr(1, 3, 4);
        push(1, 32'h8);   // rx now holds 3 words, no overrun
        err[1] = 0;
        pop(1);
        check("R9", "rx_rdata", rx_rdata, 32'h5);
        flush(3'b001);
        check_all("R9 R7");
        check("R7", "rx_thr", rx_thr, 32'h0020_0020);
        check("R7", "tx_thr", tx_thr, 32'h0020_0020);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule